// File: doc/BRIEF.md
# Clock-Reset Control Register Bank

This block is the software-visible control surface of a clock and reset controller. It sits on a 32-bit APB slave port and holds the settings that the surrounding hardware reads. There are control, configuration and fractional registers for three PLLs, a PLL status word, divider and source-select words for the peripheral clocks, and the peripheral, CPU and memory-subsystem reset words. The PLLs, dividers and clock muxes themselves live outside the block and only consume the stored fields.

Accesses are tracked by a three-state transfer machine. `ST_IDLE` moves to `ST_SETUP` when `psel` rises without `penable`. `ST_SETUP` moves to `ST_ACCESS` when `penable` joins `psel`, and that is the only cycle in which a transfer takes effect. `ST_SETUP` stays put while `psel` is held without `penable`, and drops back to `ST_IDLE` if `psel` is withdrawn. `ST_ACCESS` goes straight to `ST_SETUP` for a back-to-back transfer, or to `ST_IDLE` otherwise.

Any access to an offset that holds no register raises a decode-error flag. That flag drives one interrupt through a mask, and the mask can only be moved by dedicated set and clear strobes. The low four bits of the CPU reset word leave the block as four per-CPU reset lines. A static strap selects whether those lines come out of reset held or released.

Top module: `clkrst_ctrl_regs`

## Requirements
- R1: A transfer takes effect only in the cycle where `psel` and `penable` are both high after a setup cycle; `prdata` is valid in that cycle. A setup cycle that is abandoned without `penable` changes nothing.
- R2: Bit 0 of the word at 0x04 is the decode-error flag; writing 1 to it clears it, and writing 0 leaves it unchanged.
- R3: Bit 0 of the word at 0x08 is the interrupt mask, resets to 1 and ignores direct writes. Writing 1 to bit 0 at 0x0C clears it, and writing 1 to bit 0 at 0x10 sets it.
- R4: The words at 0x0C and 0x10 always read as 0.
- R5: `irq_o` equals flag AND NOT mask, and follows any change of either from the clock edge that commits it.
- R6: A read or write at an unmapped or misaligned offset (for example 0x14, 0x10C, 0x1FC or 0x22) reads 0, alters no register and sets the decode-error flag.
- R7: The PLL status word at 0x44 resets to 0x3F; bits 5:0 ignore writes, bits 7:6 are reserved, and bits 31:8 are writable.
- R8: Reset values: 0x12C09, 0x2C09 and 0x12809 for the PLL control words at 0x20, 0x2C and 0x38; 0x3000400 for the CPU clock word at 0x60; 0x1000500 for the DDR clock word at 0x80.
- R9: Reserved bits read 0 and ignore writes. The reserved masks are 0xF88C80F6 for PLL control words, 0xFCFFC0F8 at 0x60 and 0xFEFFC0F8 for most clock words, 0x80 included.
- R10: With the strap low, the CPU reset word at 0x104 resets to 0x3D0F. Its bits 3:0 drive `cpu_rst_o[3:0]`, where 1 holds that CPU in reset. The word's reserved mask is 0xC2F0.
- R11: With the strap high, the CPU reset word resets to 0x3D00, so all four CPU reset lines are low from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_release_i | input | 1 | Static strap: 1 releases the CPU reset lines at reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| irq_o | output | 1 | Decode-error interrupt, level |
| cpu_rst_o | output | NCPU | Per-CPU reset, 1 = held |

## Verification
The bench targets the aliasing traps. A misaligned write one byte above a PLL control word must not land in that word. A direct write of 0 to the mask word must not unmask the interrupt. If either went wrong, a stored field would change, or `irq_o` would fire while software still believed it masked. The bench writes all ones to PLL, clock, status and CPU reset words: a wrong reserved mask shows up as stray bits on readback, and a writable status field shows up as lost lock flags. Writing 0 to the flag checks that the clear is write-one-only. The strap case is run under a second reset, where a design that ignored the strap would hold all four CPUs.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;

    localparam int DATA_W = 32;

    // What a word slot holds.
    typedef enum logic [2:0] {
        K_NONE,    // no register: decode error
        K_STORE,   // plain read/write with reserved mask
        K_RO6,     // PLL status: bits 5:0 fixed
        K_CPURST,  // CPU reset word, low bits leave the block
        K_IRQ      // flag / mask / set / clear strobes
    } kind_e;

    function automatic kind_e reg_kind(input int off);
        case (off)
            'h04, 'h08, 'h0C, 'h10:                         return K_IRQ;
            'h44:                                           return K_RO6;
            'h104:                                          return K_CPURST;
            'h20, 'h2C, 'h38, 'h24, 'h30, 'h3C,
            'h28, 'h34, 'h40, 'h48, 'h4C, 'h50,
            'h60, 'h64, 'h68, 'h70, 'h74, 'h7C,
            'h80, 'h84, 'hA0, 'hB4, 'hB8, 'hBC,
            'hC0, 'hC4, 'hF8, 'h00, 'h1C, 'h100, 'h108:     return K_STORE;
            default:                                        return K_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_rst(input int off);
        case (off)
            'h20:               return 32'h0001_2C09;
            'h2C:               return 32'h0000_2C09;
            'h38:               return 32'h0001_2809;
            'h44:               return 32'h0000_003F;
            'h48, 'h4C, 'h50:   return 32'h0000_0400;
            'h60:               return 32'h0300_0400;
            'h64:               return 32'h0000_2500;
            'h68:               return 32'h0100_2500;
            'h70:               return 32'h0100_2300;
            'h74:               return 32'h0103_2300;
            'h7C:               return 32'h0120_3200;
            'h84, 'hB4:         return 32'h0000_1500;
            'h80, 'hB8, 'hBC:   return 32'h0100_0500;
            'hA0:               return 32'h0100_1600;
            'hC0:               return 32'h0100_0400;
            'hC4:               return 32'h0100_0800;
            'hF8:               return 32'h0000_0A00;
            'h100:              return 32'h000F_9FFE;
            'h104:              return 32'h0000_3D0F;
            'h108:              return 32'h0000_000F;
            default:            return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_rsvd(input int off);
        case (off)
            'h20, 'h2C, 'h38:                   return 32'hF88C_80F6;
            'h24, 'h30, 'h3C:                   return 32'h0180_1210;
            'h28, 'h34, 'h40:                   return 32'h7E33_0000;
            'h44:                               return 32'h0000_00C0;
            'h48, 'h4C, 'h50:                   return 32'h0000_C0FF;
            'h60:                               return 32'hFCFF_C0F8;
            'h70, 'h74, 'h7C:                   return 32'hFEC0_C0F8;
            'h84:                               return 32'hF8FF_C0F8;
            'hF8:                               return 32'hFFFF_C0F8;
            'h64, 'h68, 'h80, 'hA0, 'hB4,
            'hB8, 'hBC, 'hC0, 'hC4:             return 32'hFEFF_C0F8;
            'h100:                              return 32'h00F0_6001;
            'h104:                              return 32'h0000_C2F0;
            'h108:                              return 32'h0000_00F3;
            'h00, 'h1C:                         return 32'hFFFF_FFFE;
            default:                            return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/clkrst_apb_fsm.sv
module clkrst_apb_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb,
    output logic rd_stb
);
    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACCESS} apb_st_e;

    apb_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = ST_IDLE;
        unique case (st_q)
            ST_IDLE:   st_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            ST_SETUP:  st_d = (psel && penable) ? ST_ACCESS :
                              (psel ? ST_SETUP : ST_IDLE);
            ST_ACCESS: st_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        if (st_q == ST_SETUP && psel && penable) begin
            wr_stb = pwrite;
            rd_stb = !pwrite;
        end
    end

    // R1: a committed transfer is never repeated in the following cycle
    a_r1_one_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_stb) |=> !(wr_stb || rd_stb));

endmodule

// File: rtl/clkrst_irq.sv
module clkrst_irq #(
    parameter int IDX_W = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_stb,
    input  logic                            rd_stb,
    input  logic                            mapped,
    input  logic [IDX_W-1:0]                widx,
    input  logic                            wbit0,
    output logic [clkrst_pkg::DATA_W-1:0]   rdata,
    output logic                            irq_o
);
    localparam logic [IDX_W-1:0] IDX_FLAG = IDX_W'('h04 >> 2);
    localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'('h08 >> 2);
    localparam logic [IDX_W-1:0] IDX_SET  = IDX_W'('h0C >> 2);
    localparam logic [IDX_W-1:0] IDX_CLR  = IDX_W'('h10 >> 2);

    logic flag_q, mask_q;
    logic bad_acc;

    assign bad_acc = (wr_stb || rd_stb) && !mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            mask_q <= 1'b1;
        end else begin
            if (bad_acc)
                flag_q <= 1'b1;
            else if (wr_stb && widx == IDX_FLAG && wbit0)
                flag_q <= 1'b0;
            if (wr_stb && mapped && widx == IDX_SET && wbit0)
                mask_q <= 1'b0;
            else if (wr_stb && mapped && widx == IDX_CLR && wbit0)
                mask_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (mapped && widx == IDX_FLAG) rdata[0] = flag_q;
        if (mapped && widx == IDX_MASK) rdata[0] = mask_q;
    end

    assign irq_o = flag_q && !mask_q;

    a_r2_flag_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mapped && widx == IDX_FLAG && wbit0) |=> !irq_o);
    a_r3_set_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mapped && widx == IDX_SET && wbit0) |=> (irq_o == flag_q));
    a_r3_clr_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mapped && widx == IDX_CLR && wbit0) |=> !irq_o);
    a_r6_err_flags: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |=> flag_q);
    a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(wr_stb || rd_stb));

endmodule

// File: rtl/clkrst_regfile.sv
module clkrst_regfile
    import clkrst_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int NCPU  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_release_i,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCPU-1:0]   cpu_rst
);
    localparam int NSLOT = 2 ** IDX_W;
    localparam logic [IDX_W-1:0] CPU_IDX  = IDX_W'('h104 >> 2);
    localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'('h44 >> 2);
    localparam logic [DATA_W-1:0] CPU_BITS = DATA_W'((64'd1 << NCPU) - 1);

    logic [DATA_W-1:0] word_q [NSLOT];

    for (genvar w = 0; w < NSLOT; w++) begin : g_word
        localparam kind_e             KIND = reg_kind(w * 4);
        localparam logic [DATA_W-1:0] RSTV = reg_rst(w * 4);
        localparam logic [DATA_W-1:0] RSVD = reg_rsvd(w * 4);
        if (KIND == K_STORE || KIND == K_RO6 || KIND == K_CPURST) begin : g_reg
            localparam logic [DATA_W-1:0] HOLD = (KIND == K_RO6) ? 32'h3F : 32'h0;
            logic [DATA_W-1:0] q, init;
            assign init = (KIND == K_CPURST && strap_release_i) ? (RSTV & ~CPU_BITS) : RSTV;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= init;
                else if (wr_en && widx == IDX_W'(w))
                    q <= (wdata & ~RSVD & ~HOLD) | (q & HOLD);
            end
            assign word_q[w] = q & ~RSVD;
        end else begin : g_void
            assign word_q[w] = '0;
        end
    end

    assign rdata   = word_q[widx];
    assign cpu_rst = word_q[CPU_IDX][NCPU-1:0];

    a_r10_cpu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && widx == CPU_IDX) |=> $stable(cpu_rst));
    a_r7_lock_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == STAT_IDX) |=> (word_q[STAT_IDX][5:0] == 6'h3F));

endmodule

// File: rtl/clkrst_ctrl_regs.sv
module clkrst_ctrl_regs
    import clkrst_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int NCPU   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_release_i,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq_o,
    output logic [NCPU-1:0]   cpu_rst_o
);
    localparam int IDX_W    = ADDR_W - 2;
    localparam int LAST_OFF = 'h108;
    localparam int NWORDS   = LAST_OFF / 4 + 1;

    logic             wr_stb, rd_stb;
    logic             aligned, mapped;
    logic [IDX_W-1:0] widx;
    logic [DATA_W-1:0] rf_rdata, irq_rdata;

    assign widx    = paddr[ADDR_W-1:2];
    assign aligned = (paddr[1:0] == 2'b00);
    assign mapped  = aligned && (int'(widx) < NWORDS) &&
                     (reg_kind(int'(widx) * 4) != K_NONE);

    clkrst_apb_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb)
    );

    clkrst_irq #(.IDX_W(IDX_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb),
        .mapped (mapped),
        .widx   (widx),
        .wbit0  (pwdata[0]),
        .rdata  (irq_rdata),
        .irq_o  (irq_o)
    );

    clkrst_regfile #(.IDX_W(IDX_W), .NCPU(NCPU)) u_rf (
        .clk             (clk),
        .rst_n           (rst_n),
        .strap_release_i (strap_release_i),
        .wr_en           (wr_stb && mapped),
        .widx            (widx),
        .wdata           (pwdata),
        .rdata           (rf_rdata),
        .cpu_rst         (cpu_rst_o)
    );

    assign prdata = mapped ? (rf_rdata | irq_rdata) : '0;

    // R6: a misaligned or unmapped read never returns data
    a_r6_bad_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !mapped) |-> (prdata == '0));

endmodule

// File: tb/clkrst_ctrl_regs_bench.sv
module clkrst_ctrl_regs_bench;
    localparam int HALF = 10;   // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [8:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        irq;
    logic [3:0]  cpu_rst;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0;

    // behavioural model
    bit          m_flag, m_mask;
    logic [31:0] m_cpu;
    logic [31:0] mreg [int];

    always #HALF clk = ~clk;

    clkrst_ctrl_regs u_clkrst_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .strap_release_i(strap),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq_o(irq), .cpu_rst_o(cpu_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every clock: interrupt and CPU reset lines against the model
    always @(negedge clk) begin
        #1;
        if (cmp_on) begin
            chk("R5 irq_o", {31'b0, irq}, {31'b0, m_flag & ~m_mask});
            chk("R10 cpu_rst_o", {28'b0, cpu_rst}, {28'b0, m_cpu[3:0]});
        end
    end

    function automatic bit is_bad(input int off);
        return (off % 4 != 0) || off == 'h14 || off == 'h10C || off == 'h1FC;
    endfunction

    function automatic logic [31:0] model_read(input int off);
        if (is_bad(off))           return 32'h0;
        if (off == 'h04)           return {31'b0, m_flag};
        if (off == 'h08)           return {31'b0, m_mask};
        if (off == 'h0C || off == 'h10) return 32'h0;
        if (off == 'h104)          return m_cpu;
        return mreg[off];
    endfunction

    task automatic model_write(input int off, input logic [31:0] d);
        if (is_bad(off))          m_flag = 1;
        else if (off == 'h04)     begin if (d[0]) m_flag = 0; end
        else if (off == 'h0C)     begin if (d[0]) m_mask = 0; end
        else if (off == 'h10)     begin if (d[0]) m_mask = 1; end
        else if (off == 'h104)    m_cpu = d & ~32'h0000_C2F0;
        else if (off == 'h44)     mreg[off] = (d & 32'hFFFF_FF00) | 32'h3F;
        else if (off == 'h20 || off == 'h2C || off == 'h38) mreg[off] = d & ~32'hF88C_80F6;
        else if (off == 'h60)     mreg[off] = d & ~32'hFCFF_C0F8;
        else if (off == 'h80)     mreg[off] = d & ~32'hFEFF_C0F8;
    endtask

    task automatic apb(input bit wr, input int off, input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = off[8:0]; pwdata = d;
        @(negedge clk);
        penable = 1;
        #1 q = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
        if (wr) model_write(off, d);
        else if (is_bad(off)) m_flag = 1;
    endtask

    task automatic wr(input int off, input logic [31:0] d);
        logic [31:0] q;
        apb(1, off, d, q);
    endtask

    task automatic rd(input string req, input int off);
        logic [31:0] q, e;
        e = model_read(off);
        apb(0, off, 32'h0, q);
        chk(req, q, e);
    endtask

    task automatic do_reset(input bit s);
        cmp_on = 0;
        @(negedge clk);
        strap = s; rst_n = 0;
        m_flag = 0; m_mask = 1;
        m_cpu = s ? 32'h3D00 : 32'h3D0F;
        mreg['h20] = 32'h0001_2C09; mreg['h2C] = 32'h0000_2C09;
        mreg['h38] = 32'h0001_2809; mreg['h60] = 32'h0300_0400;
        mreg['h80] = 32'h0100_0500; mreg['h44] = 32'h0000_003F;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;
    endtask

    initial begin
        #(HALF * 2 * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset(0);
        // reset state
        rd("R8 pll ctrl 0x20 reset", 'h20);
        rd("R8 pll ctrl 0x2C reset", 'h2C);
        rd("R8 pll ctrl 0x38 reset", 'h38);
        rd("R8 cpu clock reset", 'h60);
        rd("R8 ddr clock reset", 'h80);
        rd("R7 pll status reset", 'h44);
        rd("R10 cpu reset word", 'h104);
        rd("R3 mask reset", 'h08);
        rd("R2 flag reset", 'h04);
        rd("R4 set strobe reads 0", 'h0C);
        rd("R4 clear strobe reads 0", 'h10);

        // R9 reserved masks
        wr('h20, 32'hFFFF_FFFF); rd("R9 pll ctrl mask", 'h20);
        wr('h80, 32'hFFFF_FFFF); rd("R9 clock mask", 'h80);
        wr('h60, 32'hFFFF_FFFF); rd("R9 cpu clock mask", 'h60);
        wr('h20, 32'h0);         rd("R9 pll ctrl cleared", 'h20);

        // R7 status word
        wr('h44, 32'h0);         rd("R7 lock bits kept", 'h44);
        wr('h44, 32'hFFFF_FFFF); rd("R7 upper writable", 'h44);

        // R1 abandoned setup phase writes nothing
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 9'h2C; pwdata = 32'h0;
        @(negedge clk); psel = 0;
        rd("R1 abandoned setup", 'h2C);

        // R6 / R2 / R3 / R5 interrupt path
        rd("R6 unmapped read 0x14", 'h14);
        rd("R2 flag set by error", 'h04);
        wr('h08, 32'h0);         rd("R3 direct mask write ignored", 'h08);
        wr('h0C, 32'h1);         rd("R3 set strobe unmasks", 'h08);
        chk("R5 irq after unmask", {31'b0, irq}, 32'h1);
        rd("R4 set strobe still 0", 'h0C);
        wr('h04, 32'h0);         rd("R2 write 0 keeps flag", 'h04);
        wr('h04, 32'h1);         rd("R2 write 1 clears flag", 'h04);
        chk("R5 irq after clear", {31'b0, irq}, 32'h0);
        wr('h22, 32'h0);         rd("R6 misaligned write ignored", 'h20);
        rd("R6 misaligned flags", 'h04);
        wr('h04, 32'h1);
        wr('h10C, 32'hFFFF_FFFF); rd("R6 write beyond map", 'h04);
        rd("R6 read 0x1FC", 'h1FC);
        wr('h10, 32'h1);         rd("R3 clear strobe masks", 'h08);
        chk("R5 irq masked", {31'b0, irq}, 32'h0);
        wr('h0C, 32'h1);         chk("R5 irq unmasked again", {31'b0, irq}, 32'h1);

        // R10 CPU reset lines
        wr('h104, 32'h5);        rd("R10 cpu word write", 'h104);
        chk("R10 cpu lines 0101", {28'b0, cpu_rst}, 32'h5);
        wr('h104, 32'hFFFF_FFFF); rd("R10 cpu reserved", 'h104);

        // R11 strap released
        do_reset(1);
        @(negedge clk);
        chk("R11 cpu lines released", {28'b0, cpu_rst}, 32'h0);
        rd("R11 cpu word value", 'h104);
        rd("R11 mask reset", 'h08);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule